// File: doc/BRIEF.md
# Three-Level Auxiliary Table Walker

This block turns a 48-bit main-surface virtual address into the address of its auxiliary data and the surface descriptor that goes with it. To do this it reads three 64-bit table entries from memory in turn. A request arrives on a valid/ready handshake. The block then issues one read at a time on a single-word memory port. It returns one response per request. The response carries the auxiliary address, a format code, a depth code, a tile mode and a Y/Cr flag, or a fault flag.

The address is split into indices of uneven width: 12 bits at the top level, 12 bits in the middle and 8 bits at the leaf. The low 16 bits play no part in the lookup. Each level reads its entry at the table address plus eight times its index. The table pointer held in an entry is masked to a different alignment at each level. Every address the block puts out is in canonical form, with bit 47 copied into bits 63:48.

Only one walk is in flight at a time. A new request is taken only when the walker is idle. The next request can be taken once the previous response has been handed over.

Top module: `auxmap_walker`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and mem_req_valid is 0.
- R2: The first read of a walk goes to canonical(base_addr + 8 * vaddr[47:36]). The sum is taken in 48 bits, and bits 63:48 of the read address equal bit 47.
- R3: When the first entry is valid, the second read goes to canonical({entry[47:15], 15'b0} + 8 * vaddr[35:24]).
- R4: When the second entry is valid, the third read goes to canonical({entry[47:13], 13'b0} + 8 * vaddr[23:16]).
- R5: A valid leaf with tile mode 0 or 1 gives a non-fault response with these fields: rsp_aux_addr = canonical({leaf[47:8], 8'b0}), rsp_fmt = leaf[63:58], rsp_ycr = leaf[57], rsp_depth = leaf[56:54] and rsp_tile = leaf[53:52].
- R6: An entry at any level with bit 0 clear ends the walk at once. The response has rsp_fault = 1 and every other field 0, and no further read is issued for that walk.
- R7: A leaf whose tile mode is 2 or 3 gives a fault response with all other fields 0.
- R8: req_ready is 1 exactly while no walk is in progress. A walk lasts from its acceptance until its response is taken with rsp_valid and rsp_ready both high.
- R9: While rsp_valid is high and rsp_ready is low, the response stays valid and unchanged.
- R10: mem_req_valid stays high with a stable address until mem_req_ready is seen. A walk issues at most three reads. The result does not depend on vaddr[15:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_addr | input | 48 | Address of the top-level table |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 48 | Main-surface address to translate |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 64 | Canonical byte address of the 64-bit entry |
| mem_rsp_valid | input | 1 | Read data present (one pulse per accepted read) |
| mem_rsp_data | input | 64 | Entry word returned by memory |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_fault | output | 1 | Walk hit an invalid entry or a reserved tile mode |
| rsp_aux_addr | output | 64 | Canonical auxiliary-data address |
| rsp_fmt | output | 6 | Format code from the leaf |
| rsp_depth | output | 3 | Depth code from the leaf |
| rsp_tile | output | 2 | Tile mode (0 or 1 on success) |
| rsp_ycr | output | 1 | Y/Cr plane flag |

## Verification
The properties assume three things about the environment. Memory returns exactly one data pulse for each accepted read, and only after accepting it. base_addr and the table contents stay put while a walk is running. The bench's memory model keeps to all three. It answers each accepted read once, one to three cycles later. It edits tables and changes the base only after every expected response has been drained. It throttles both mem_req_ready and rsp_ready on fixed patterns, so that the hold behaviour on both handshakes is exercised.

// File: rtl/auxwalk_pkg.sv
`timescale 1ns/1ps
package auxwalk_pkg;
  localparam int VA_W        = 48;
  localparam int ENT_W       = 64;
  localparam int ENTRY_SHIFT = 3;
  // index slices of the virtual address
  localparam int TOP_IDX_LSB = 36;
  localparam int TOP_IDX_W   = 12;
  localparam int MID_IDX_LSB = 24;
  localparam int MID_IDX_W   = 12;
  localparam int LEAF_IDX_LSB = 16;
  localparam int LEAF_IDX_W   = 8;
  // pointer alignment in each level's entry
  localparam int MID_PTR_LSB  = 15;
  localparam int LEAF_PTR_LSB = 13;
  localparam int AUX_LSB      = 8;
  // leaf attribute fields
  localparam int FMT_LSB   = 58;
  localparam int FMT_W     = 6;
  localparam int YCR_BIT   = 57;
  localparam int DEPTH_LSB = 54;
  localparam int DEPTH_W   = 3;
  localparam int TILE_LSB  = 52;
  localparam int TILE_W    = 2;
  localparam int TILE_MAX_LEGAL = 1;
  localparam int VALID_BIT = 0;

  typedef enum logic [2:0] {
    WK_IDLE  = 3'd0,
    WK_RD_L3 = 3'd1,
    WK_RD_L2 = 3'd2,
    WK_RD_L1 = 3'd3,
    WK_RESP  = 3'd4
  } walk_state_e;

  typedef struct packed {
    logic               fault;
    logic [ENT_W-1:0]   aux;
    logic [FMT_W-1:0]   fmt;
    logic [DEPTH_W-1:0] depth;
    logic [TILE_W-1:0]  tile;
    logic               ycr;
  } walk_rsp_t;
endpackage

// File: rtl/auxwalk_ptr_calc.sv
`timescale 1ns/1ps
module auxwalk_ptr_calc #(
  parameter int AW          = 48,
  parameter int OW          = 64,
  parameter int IDX_W       = 12,
  parameter int PTR_LSB     = 15,
  parameter int ENTRY_SHIFT = 3
) (
  input  logic [AW-1:0]    tbl_ptr,
  input  logic [IDX_W-1:0] idx,
  output logic [OW-1:0]    rd_addr
);
  localparam logic [AW-1:0] PTR_MASK = ~((AW'(1) << PTR_LSB) - AW'(1));

  logic [AW-1:0] sum;

  assign sum     = (tbl_ptr & PTR_MASK) + (AW'(idx) << ENTRY_SHIFT);
  // canonical form: copy the top address bit upward
  assign rd_addr = {{(OW-AW){sum[AW-1]}}, sum};
endmodule

// File: rtl/auxwalk_leaf_dec.sv
`timescale 1ns/1ps
module auxwalk_leaf_dec
  import auxwalk_pkg::*;
#(
  parameter int AW = VA_W,
  parameter int OW = ENT_W
) (
  input  logic [OW-1:0] entry,
  output walk_rsp_t     leaf
);
  localparam logic [AW-1:0] AUX_MASK = ~((AW'(1) << AUX_LSB) - AW'(1));

  logic [AW-1:0]     aux_raw;
  logic [TILE_W-1:0] tile;
  logic              bad;
  logic              unused_bits;

  assign aux_raw     = entry[AW-1:0] & AUX_MASK;
  assign tile        = entry[TILE_LSB +: TILE_W];
  assign bad         = !entry[VALID_BIT] || (tile > TILE_W'(TILE_MAX_LEGAL));
  assign unused_bits = ^{entry[TILE_LSB-1:AW], entry[AUX_LSB-1:1]};

  always_comb begin
    leaf = '0;
    if (bad) begin
      leaf.fault = 1'b1;
    end else begin
      leaf.aux   = {{(OW-AW){aux_raw[AW-1]}}, aux_raw};
      leaf.fmt   = entry[FMT_LSB +: FMT_W];
      leaf.depth = entry[DEPTH_LSB +: DEPTH_W];
      leaf.tile  = tile;
      leaf.ycr   = entry[YCR_BIT];
    end
  end
endmodule

// File: rtl/auxwalk_ctrl.sv
`timescale 1ns/1ps
module auxwalk_ctrl
  import auxwalk_pkg::*;
#(
  parameter int AW = VA_W,
  parameter int OW = ENT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_vaddr,
  output logic [AW-1:0] va_q,
  input  logic [OW-1:0] top_addr,
  input  logic [OW-1:0] mid_addr,
  input  logic [OW-1:0] leaf_addr,
  input  walk_rsp_t     leaf,
  input  logic          entry_vld,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [OW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output walk_rsp_t     rsp
);
  walk_state_e   st_q, st_d;
  logic          sent_q, sent_d;
  logic [OW-1:0] addr_q, addr_d;
  logic          addr_en, va_en, rsp_en;
  walk_rsp_t     rsp_q, rsp_d;
  logic          reading, got_word;

  assign reading  = (st_q == WK_RD_L3) || (st_q == WK_RD_L2) || (st_q == WK_RD_L1);
  assign got_word = reading && sent_q && mem_rsp_valid;

  always_comb begin
    st_d    = st_q;
    sent_d  = sent_q;
    addr_d  = addr_q;
    addr_en = 1'b0;
    va_en   = 1'b0;
    rsp_d   = rsp_q;
    rsp_en  = 1'b0;
    case (st_q)
      WK_IDLE: begin
        if (req_valid) begin
          va_en   = 1'b1;
          addr_en = 1'b1;
          addr_d  = top_addr;
          sent_d  = 1'b0;
          st_d    = WK_RD_L3;
        end
      end
      WK_RD_L3, WK_RD_L2, WK_RD_L1: begin
        if (!sent_q && mem_req_ready) sent_d = 1'b1;
        if (got_word) begin
          if (!entry_vld) begin
            rsp_en      = 1'b1;
            rsp_d       = '0;
            rsp_d.fault = 1'b1;
            st_d        = WK_RESP;
          end else begin
            case (st_q)
              WK_RD_L3: begin
                addr_en = 1'b1;
                addr_d  = mid_addr;
                sent_d  = 1'b0;
                st_d    = WK_RD_L2;
              end
              WK_RD_L2: begin
                addr_en = 1'b1;
                addr_d  = leaf_addr;
                sent_d  = 1'b0;
                st_d    = WK_RD_L1;
              end
              default: begin
                rsp_en = 1'b1;
                rsp_d  = leaf;
                st_d   = WK_RESP;
              end
            endcase
          end
        end
      end
      WK_RESP: begin
        if (rsp_ready) st_d = WK_IDLE;
      end
      default: st_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WK_IDLE;
      sent_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sent_q <= sent_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     va_q <= '0;
    else if (va_en) va_q <= req_vaddr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rsp_q <= '0;
    else if (rsp_en) rsp_q <= rsp_d;
  end

  assign req_ready     = (st_q == WK_IDLE);
  assign mem_req_valid = reading && !sent_q;
  assign mem_req_addr  = addr_q;
  assign rsp_valid     = (st_q == WK_RESP);
  assign rsp           = rsp_q;
endmodule

// File: rtl/auxmap_walker.sv
`timescale 1ns/1ps
module auxmap_walker
  import auxwalk_pkg::*;
#(
  parameter int AW = VA_W,
  parameter int OW = ENT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        base_addr,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [AW-1:0]        req_vaddr,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [OW-1:0]        mem_req_addr,
  input  logic                 mem_rsp_valid,
  input  logic [OW-1:0]        mem_rsp_data,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic                 rsp_fault,
  output logic [OW-1:0]        rsp_aux_addr,
  output logic [FMT_W-1:0]     rsp_fmt,
  output logic [DEPTH_W-1:0]   rsp_depth,
  output logic [TILE_W-1:0]    rsp_tile,
  output logic                 rsp_ycr
);
  logic [AW-1:0] va_q;
  logic [OW-1:0] top_addr, mid_addr, leaf_addr;
  walk_rsp_t     leaf, rsp;
  logic          unused_va;

  assign unused_va = ^{va_q[AW-1:TOP_IDX_LSB], va_q[LEAF_IDX_LSB-1:0]};

  auxwalk_ptr_calc #(.AW(AW), .OW(OW), .IDX_W(TOP_IDX_W), .PTR_LSB(0),
                     .ENTRY_SHIFT(ENTRY_SHIFT)) top_calc_i (
    .tbl_ptr (base_addr),
    .idx     (req_vaddr[TOP_IDX_LSB +: TOP_IDX_W]),
    .rd_addr (top_addr)
  );

  auxwalk_ptr_calc #(.AW(AW), .OW(OW), .IDX_W(MID_IDX_W), .PTR_LSB(MID_PTR_LSB),
                     .ENTRY_SHIFT(ENTRY_SHIFT)) mid_calc_i (
    .tbl_ptr (mem_rsp_data[AW-1:0]),
    .idx     (va_q[MID_IDX_LSB +: MID_IDX_W]),
    .rd_addr (mid_addr)
  );

  auxwalk_ptr_calc #(.AW(AW), .OW(OW), .IDX_W(LEAF_IDX_W), .PTR_LSB(LEAF_PTR_LSB),
                     .ENTRY_SHIFT(ENTRY_SHIFT)) leaf_calc_i (
    .tbl_ptr (mem_rsp_data[AW-1:0]),
    .idx     (va_q[LEAF_IDX_LSB +: LEAF_IDX_W]),
    .rd_addr (leaf_addr)
  );

  auxwalk_leaf_dec #(.AW(AW), .OW(OW)) leaf_dec_i (
    .entry (mem_rsp_data),
    .leaf  (leaf)
  );

  auxwalk_ctrl #(.AW(AW), .OW(OW)) ctrl_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .va_q          (va_q),
    .top_addr      (top_addr),
    .mid_addr      (mid_addr),
    .leaf_addr     (leaf_addr),
    .leaf          (leaf),
    .entry_vld     (mem_rsp_data[VALID_BIT]),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp           (rsp)
  );

  assign rsp_fault    = rsp.fault;
  assign rsp_aux_addr = rsp.aux;
  assign rsp_fmt      = rsp.fmt;
  assign rsp_depth    = rsp.depth;
  assign rsp_tile     = rsp.tile;
  assign rsp_ycr      = rsp.ycr;
endmodule

// File: rtl/auxmap_walker_chk.sv
`timescale 1ns/1ps
module auxmap_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [63:0] mem_req_addr,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic        rsp_fault,
  input logic [63:0] rsp_aux_addr,
  input logic [5:0]  rsp_fmt,
  input logic [2:0]  rsp_depth,
  input logic [1:0]  rsp_tile,
  input logic        rsp_ycr
);
  // R2
  canon_rd_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[63:48] == {16{mem_req_addr[47]}}));

  // R10
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_fault) && $stable(rsp_aux_addr) && $stable(rsp_fmt)
       && $stable(rsp_depth) && $stable(rsp_tile) && $stable(rsp_ycr)));

  // R8
  one_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && !rsp_valid));

  // R8
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_req_valid) |-> !req_ready);

  // R6
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |->
      (rsp_aux_addr == 64'd0 && rsp_fmt == 6'd0 && rsp_depth == 3'd0
       && rsp_tile == 2'd0 && !rsp_ycr));

  // R7
  tile_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_tile < 2'd2));

  // R5
  aux_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |->
      (rsp_aux_addr[7:0] == 8'd0 && rsp_aux_addr[63:48] == {16{rsp_aux_addr[47]}}));
endmodule

bind auxmap_walker auxmap_walker_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_fault     (rsp_fault),
  .rsp_aux_addr  (rsp_aux_addr),
  .rsp_fmt       (rsp_fmt),
  .rsp_depth     (rsp_depth),
  .rsp_tile      (rsp_tile),
  .rsp_ycr       (rsp_ycr)
);

// File: tb/auxmap_walker_tb_top.sv
`timescale 1ns/1ps
module auxmap_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [47:0] base_addr;
  logic        req_valid;
  logic        req_ready;
  logic [47:0] req_vaddr;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        rsp_valid;
  logic        rsp_ready;
  logic        rsp_fault;
  logic [63:0] rsp_aux_addr;
  logic [5:0]  rsp_fmt;
  logic [2:0]  rsp_depth;
  logic [1:0]  rsp_tile;
  logic        rsp_ycr;

  always #2.5 clk = ~clk;

  auxmap_walker dut_i (
    .clk(clk), .rst_n(rst_n), .base_addr(base_addr),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_fault(rsp_fault), .rsp_aux_addr(rsp_aux_addr), .rsp_fmt(rsp_fmt),
    .rsp_depth(rsp_depth), .rsp_tile(rsp_tile), .rsp_ycr(rsp_ycr)
  );

  int checks = 0;
  int fails  = 0;
  logic [63:0] mem [logic [63:0]];
  logic [63:0] exp_addr_q[$];
  string       exp_lvl_q[$];
  logic [76:0] exp_rsp_q[$];
  string       exp_tag_q[$];

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] canon(input logic [47:0] a);
    return {{16{a[47]}}, a};
  endfunction

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  function automatic logic [63:0] slot(input logic [47:0] tbl, input logic [11:0] idx);
    logic [47:0] s;
    s = tbl + {33'd0, idx, 3'b000};
    return canon(s);
  endfunction

  function automatic logic [63:0] mk_top(input logic [47:0] p);
    return {16'hBEEF, p[47:15], 14'h1555, 1'b1};
  endfunction

  function automatic logic [63:0] mk_mid(input logic [47:0] p);
    return {16'hCAFE, p[47:13], 12'hABC, 1'b1};
  endfunction

  function automatic logic [63:0] mk_leaf(input logic [5:0] f, input logic y,
      input logic [2:0] d, input logic [1:0] t, input logic [47:0] aux, input logic v);
    return {f, y, d, t, 4'h9, aux[47:8], 7'h5A, v};
  endfunction

  // Behavioural reference: walk the bench memory and queue what must be seen.
  task automatic expect_walk(input logic [47:0] va, input string ok_tag);
    logic [47:0] s;
    logic [63:0] a, e;
    s = base_addr + {33'd0, va[47:36], 3'b000};
    a = canon(s); exp_addr_q.push_back(a); exp_lvl_q.push_back("R2"); e = rd(a);
    if (!e[0]) begin exp_rsp_q.push_back({1'b1, 76'd0}); exp_tag_q.push_back("R6"); return; end
    s = {e[47:15], 15'd0} + {33'd0, va[35:24], 3'b000};
    a = canon(s); exp_addr_q.push_back(a); exp_lvl_q.push_back("R3"); e = rd(a);
    if (!e[0]) begin exp_rsp_q.push_back({1'b1, 76'd0}); exp_tag_q.push_back("R6"); return; end
    s = {e[47:13], 13'd0} + {37'd0, va[23:16], 3'b000};
    a = canon(s); exp_addr_q.push_back(a); exp_lvl_q.push_back("R4"); e = rd(a);
    if (!e[0]) begin exp_rsp_q.push_back({1'b1, 76'd0}); exp_tag_q.push_back("R6"); return; end
    if (e[53:52] >= 2'd2) begin exp_rsp_q.push_back({1'b1, 76'd0}); exp_tag_q.push_back("R7"); return; end
    exp_rsp_q.push_back({1'b0, canon({e[47:8], 8'd0}), e[63:58], e[56:54], e[53:52], e[57]});
    exp_tag_q.push_back(ok_tag);
  endtask

  // Monitor / memory model state
  int          cyc = 0;
  bit          busy = 0;
  bit          acc = 0;
  bit          prev_hold = 0;
  logic [76:0] prev_rsp;
  bit          pend = 0;
  int          dly = 0;
  logic [63:0] pdata;

  always @(negedge clk) begin
    logic [76:0] cur;
    logic [63:0] ea;
    logic [76:0] er;
    string       tg;
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
    // drive memory and consumer for the coming edge
    mem_req_ready = (cyc % 3) != 2;
    rsp_ready     = (cyc % 4) != 1;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 64'h0123_4567_89AB_CDEE;
    if (pend) begin
      if (dly == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = pdata;
        pend = 0;
      end else dly--;
    end
    #1;
    if (rst_n) begin
      cur = {rsp_fault, rsp_aux_addr, rsp_fmt, rsp_depth, rsp_tile, rsp_ycr};
      // R8: ready only while no walk is running
      chk(req_ready == !busy, "R8", {127'd0, req_ready}, {127'd0, !busy});
      // R9: stalled response held
      if (prev_hold)
        chk(rsp_valid && cur == prev_rsp, "R9", {50'd0, rsp_valid, cur}, {50'd0, 1'b1, prev_rsp});
      if (mem_req_valid && mem_req_ready) begin
        if (exp_addr_q.size() == 0) begin
          chk(1'b0, "R6 extra read", {64'd0, mem_req_addr}, 128'd0);
        end else begin
          ea = exp_addr_q.pop_front();
          tg = exp_lvl_q.pop_front();
          chk(mem_req_addr == ea, tg, {64'd0, mem_req_addr}, {64'd0, ea});
        end
        pend  = 1;
        dly   = cyc % 3;
        pdata = rd(mem_req_addr);
      end
      if (rsp_valid && rsp_ready) begin
        if (exp_rsp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected response", {51'd0, cur}, 128'd0);
        end else begin
          er = exp_rsp_q.pop_front();
          tg = exp_tag_q.pop_front();
          chk(cur == er, tg, {51'd0, cur}, {51'd0, er});
        end
        busy = 0;
      end
      if (req_valid && req_ready) begin
        busy = 1;
        acc  = 1;
      end
      prev_hold = rsp_valid && !rsp_ready;
      prev_rsp  = cur;
    end
  end

  task automatic issue(input logic [47:0] va, input string ok_tag);
    expect_walk(va, ok_tag);
    req_vaddr = va;
    req_valid = 1'b1;
    do @(negedge clk); while (!acc);
    acc = 0;
    req_valid = 1'b0;
    req_vaddr = 48'hA5A5_A5A5_A5A5;
  endtask

  task automatic drain();
    while (exp_addr_q.size() != 0 || exp_rsp_q.size() != 0 || busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  localparam logic [47:0] TBL_MID_A  = 48'h0000_2000_8000;
  localparam logic [47:0] TBL_LEAF_A = 48'h0000_3000_2000;
  localparam logic [47:0] TBL_MID_B  = 48'h8000_0001_0000;
  localparam logic [47:0] TBL_LEAF_B = 48'hC000_0000_4000;

  initial begin
    logic [47:0] base2;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_vaddr = '0;
    base_addr = 48'h0000_1234_0000;
    base2     = 48'h0000_5550_0008;

    mem[slot(base_addr, 12'h005)]  = mk_top(TBL_MID_A);
    mem[slot(TBL_MID_A, 12'h0A3)]  = mk_mid(TBL_LEAF_A);
    mem[slot(TBL_MID_A, 12'h0A5)]  = mk_mid(TBL_LEAF_A) & ~64'd1;
    mem[slot(TBL_LEAF_A, 12'h04C)] = mk_leaf(6'h11, 1'b1, 3'd5, 2'd1, 48'h0000_4567_8900, 1'b1);
    mem[slot(TBL_LEAF_A, 12'h04D)] = mk_leaf(6'h0A, 1'b0, 3'd4, 2'd0, 48'h0000_0ABC_DE00, 1'b1);
    mem[slot(TBL_LEAF_A, 12'h04E)] = mk_leaf(6'h1E, 1'b1, 3'd7, 2'd2, 48'h0000_1111_2200, 1'b1);
    mem[slot(TBL_LEAF_A, 12'h04F)] = mk_leaf(6'h13, 1'b0, 3'd1, 2'd3, 48'h0000_3333_4400, 1'b1);
    mem[slot(TBL_LEAF_A, 12'h050)] = mk_leaf(6'h12, 1'b0, 3'd6, 2'd1, 48'h0000_5555_6600, 1'b0);
    mem[slot(base_addr, 12'hFFF)]  = mk_top(TBL_MID_B);
    mem[slot(TBL_MID_B, 12'h001)]  = mk_mid(TBL_LEAF_B);
    mem[slot(TBL_LEAF_B, 12'h0FF)] = mk_leaf(6'h3F, 1'b1, 3'd7, 2'd0, 48'hF000_0000_0100, 1'b1);
    mem[slot(base2, 12'h005)]      = mk_top(TBL_MID_A);

    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1",
        {125'd0, req_ready, rsp_valid, mem_req_valid}, {125'd0, 3'b100});
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    issue({12'h005, 12'h0A3, 8'h4C, 16'h0000}, "R5");   // full walk, tile Y
    issue({12'h005, 12'h0A3, 8'h4C, 16'hFFFF}, "R10");  // low bits ignored
    issue({12'h005, 12'h0A3, 8'h4D, 16'h1234}, "R5");   // tile Ys, other fields
    issue({12'h005, 12'h0A3, 8'h4E, 16'h0000}, "R7");   // reserved tile 2
    issue({12'h005, 12'h0A3, 8'h4F, 16'h0000}, "R7");   // reserved tile 3
    issue({12'h005, 12'h0A3, 8'h50, 16'h0000}, "R6");   // leaf invalid
    issue({12'h005, 12'h0A4, 8'h4C, 16'h0000}, "R6");   // middle entry missing
    issue({12'h005, 12'h0A5, 8'h4C, 16'h0000}, "R6");   // middle entry cleared valid
    issue({12'h006, 12'h0A3, 8'h4C, 16'h0000}, "R6");   // top entry missing
    issue({12'hFFF, 12'h001, 8'hFF, 16'h8001}, "R5");   // high half, sign extension
    drain();

    base_addr = base2;                                  // R2: base moved while idle
    issue({12'h005, 12'h0A3, 8'h4C, 16'h0042}, "R5");
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule